// File: doc/BRIEF.md
# Non-Overlapping Complementary Pair Generator

This block turns each single-bit drive command into a true/complement output pair for the two switches of one bridge leg. The two outputs are never high together. When the command flips, the output that was on switches off at once. The other output switches on only after a programmable number of clock cycles in which both outputs are low. This gap must cover the turn-off time of the switch being released.

Each channel has two separate gap values: one used before the true output turns on, and one used before the complement output turns on. The two windows can therefore differ in length. The top holds one independent channel per command. By default there are two channels: channel 0 carries the pulse-width command and channel 1 carries the direction command. Direction changes therefore follow the same no-overlap rule as the PWM edges.

Top module: `nonoverlap_pair_gen`

## Requirements
- R1: While rst_ni is low both outputs of every channel are 0. After reset is released, the first rising clock edge starts a gap for the command then present, and the outputs stay 0 until that gap has elapsed.
- R2: A change of cmd_i[c] from 0 to 1 forces lo_o[c] to 0 at the first rising edge that samples the new value. A change from 1 to 0 forces hi_o[c] to 0 at that same edge.
- R3: After a 0-to-1 change, hi_o[c] rises max(D,1) cycles after lo_o[c] fell, where D is the 8-bit field hi_dly_i[8c+7:8c]. Both outputs are 0 in between.
- R4: After a 1-to-0 change, lo_o[c] rises max(D,1) cycles after hi_o[c] fell, where D is lo_dly_i[8c+7:8c]. Both outputs are 0 in between.
- R5: A delay field of 0 still gives exactly one cycle with both outputs low.
- R6: The two delay fields of a channel act independently, so the two windows may have different lengths.
- R7: If the command reverses again before the gap ends, the pending turn-on is cancelled. A new gap starts at the reversal edge using the delay of the newly selected side, and the cancelled output never rises.
- R8: hi_o[c] and lo_o[c] are never 1 in the same cycle.
- R9: Channels are independent: activity on one channel leaves the outputs of the others unchanged.
- R10: The delay is captured at the edge that sees the command change. Changing the delay input during a running gap does not alter that gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | NCH | Raw command per channel (bit 0 PWM, bit 1 direction) |
| hi_dly_i | input | NCH*DW | Per-channel gap in cycles before the true output turns on |
| lo_dly_i | input | NCH*DW | Per-channel gap in cycles before the complement output turns on |
| hi_o | output | NCH | True output per channel |
| lo_o | output | NCH | Complement output per channel |

## Verification
A command change sampled at rising edge E0 is visible on the outputs just after E0: the released output is already 0. The partner output first reads 1 just after edge E0+max(D,1). The bench therefore drives inputs and samples outputs at falling edges. For each command change it counts the falling-edge samples with both outputs low and compares that count with max(D,1). Every sample is also checked for overlap and for a rise on the wrong side. For cancellation and delay-change cases, the count restarts at the reversing edge, and the other channel's outputs are compared throughout.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned DLY_W_DEF = 8;
  localparam int unsigned NCH_DEF   = 2;
endpackage

// File: rtl/dtg_delay_cnt.sv
module dtg_delay_cnt #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  output logic          expire_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_q;
  logic          busy_q;

  // zero delay is promoted to one cycle of gap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= (load_val_i == '0) ? ONE : load_val_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == ONE) busy_q <= 1'b0;
      else              cnt_q  <= cnt_q - ONE;
    end
  end

  assign expire_o = busy_q && (cnt_q == ONE);

  p_busy_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0));

  p_load_starts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (busy_q && $past(load_val_i) <= cnt_q || ($past(load_val_i) == '0 && cnt_q == ONE)));
endmodule

// File: rtl/dtg_channel.sv
module dtg_channel #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_i,
  input  logic [DW-1:0] hi_dly_i,
  input  logic [DW-1:0] lo_dly_i,
  output logic          hi_o,
  output logic          lo_o
);
  logic          cmd_q;
  logic          reload_q;
  logic          evt;
  logic          expire;
  logic [DW-1:0] sel_dly;

  assign evt     = reload_q | (cmd_i ^ cmd_q);
  assign sel_dly = cmd_i ? hi_dly_i : lo_dly_i;

  dtg_delay_cnt #(.DW(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (evt),
    .load_val_i (sel_dly),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= 1'b0;
      reload_q <= 1'b1;
      hi_o     <= 1'b0;
      lo_o     <= 1'b0;
    end else begin
      reload_q <= 1'b0;
      if (evt) begin
        // release immediately, restart gap
        cmd_q <= cmd_i;
        hi_o  <= 1'b0;
        lo_o  <= 1'b0;
      end else if (expire) begin
        hi_o <= cmd_q;
        lo_o <= ~cmd_q;
      end
    end
  end

  p_no_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_o && lo_o));

  p_hi_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i |=> !hi_o);

  p_lo_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> !lo_o);

  p_hi_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_o) |-> (!$past(lo_o) && $past(cmd_i)));

  p_lo_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_o) |-> (!$past(hi_o) && !$past(cmd_i)));
endmodule

// File: rtl/nonoverlap_pair_gen.sv
module nonoverlap_pair_gen
  import dtg_pkg::*;
#(
  parameter int unsigned NCH = NCH_DEF,
  parameter int unsigned DW  = DLY_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    cmd_i,
  input  logic [NCH*DW-1:0] hi_dly_i,
  input  logic [NCH*DW-1:0] lo_dly_i,
  output logic [NCH-1:0]    hi_o,
  output logic [NCH-1:0]    lo_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dtg_channel #(.DW(DW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmd_i    (cmd_i[c]),
      .hi_dly_i (hi_dly_i[c*DW +: DW]),
      .lo_dly_i (lo_dly_i[c*DW +: DW]),
      .hi_o     (hi_o[c]),
      .lo_o     (lo_o[c])
    );
  end

  p_pairs_disjoint_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_o & lo_o) == '0);
endmodule

// File: tb/nonoverlap_pair_gen_tb.sv
module nonoverlap_pair_gen_tb;
  localparam int NCH = 2;
  localparam int DW  = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NCH-1:0]    cmd_i = '0;
  logic [NCH*DW-1:0] hi_dly_i = '0;
  logic [NCH*DW-1:0] lo_dly_i = '0;
  logic [NCH-1:0]    hi_o;
  logic [NCH-1:0]    lo_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  nonoverlap_pair_gen #(.NCH(NCH), .DW(DW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_dly(input int c, input int hd, input int ld);
    hi_dly_i[c*DW +: DW] = DW'(hd);
    lo_dly_i[c*DW +: DW] = DW'(ld);
  endtask

  // count falling-edge samples with both outputs low, starting one edge
  // after the command change; returns count, flags overlap / wrong rise
  task automatic count_gap(input int c, input bit tgt, output int gap, output bit bad);
    gap = 0; bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (hi_o[c] && lo_o[c]) bad = 1;
      if (!hi_o[c] && !lo_o[c]) gap++;
      else begin
        if ((tgt ? hi_o[c] : lo_o[c]) !== 1'b1) bad = 1;
        break;
      end
    end
  endtask

  task automatic edge_case(input int c, input bit nv, input int exp, input string req);
    int gap; bit bad;
    @(negedge clk_i);
    cmd_i[c] = nv;
    @(negedge clk_i);
    chk((nv ? lo_o[c] : hi_o[c]) == 1'b0, "R2", int'(nv ? lo_o[c] : hi_o[c]), 0);
    gap = 1;
    count_gap(c, nv, gap, bad);
    gap = gap + 1;
    chk(gap == exp, req, gap, exp);
    chk(!bad, "R8", int'(bad), 0);
  endtask

  task automatic t_reset;
    int gap; bit bad;
    set_dly(0, 3, 5); set_dly(1, 2, 7);
    cmd_i = 2'b10;
    repeat (3) @(negedge clk_i);
    chk(hi_o == '0 && lo_o == '0, "R1", int'({hi_o, lo_o}), 0);
    rst_ni = 1'b1;
    count_gap(0, 1'b0, gap, bad);
    chk(gap == 5, "R1", gap, 5);
    chk(hi_o[1] == 1'b1 && lo_o[1] == 1'b0, "R1", int'({hi_o[1], lo_o[1]}), 2);
  endtask

  task automatic t_basic;
    set_dly(0, 3, 5);
    edge_case(0, 1'b1, 3, "R3");
    edge_case(0, 1'b0, 5, "R4");
    set_dly(0, 1, 9);
    edge_case(0, 1'b1, 1, "R6");
    edge_case(0, 1'b0, 9, "R6");
  endtask

  task automatic t_zero;
    set_dly(0, 0, 0);
    edge_case(0, 1'b1, 1, "R5");
    edge_case(0, 1'b0, 1, "R5");
  endtask

  task automatic t_cancel;
    int gap; bit bad; bit hi_seen;
    set_dly(0, 10, 4);
    hi_seen = 0;
    @(negedge clk_i); cmd_i[0] = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      if (hi_o[0]) hi_seen = 1;
    end
    cmd_i[0] = 1'b0;
    count_gap(0, 1'b0, gap, bad);
    chk(gap == 4, "R7", gap, 4);
    chk(!bad && !hi_seen, "R7", int'(bad | hi_seen), 0);
  endtask

  task automatic t_dly_change;
    int gap; bit bad;
    set_dly(0, 6, 2);
    @(negedge clk_i); cmd_i[0] = 1'b1;
    @(negedge clk_i);
    set_dly(0, 1, 1);
    gap = 1;
    count_gap(0, 1'b1, gap, bad);
    gap = gap + 1;
    chk(gap == 6, "R10", gap, 6);
    chk(!bad, "R8", int'(bad), 0);
  endtask

  task automatic t_indep;
    logic h0, l0; bit moved; int gap; bit bad;
    h0 = hi_o[0]; l0 = lo_o[0]; moved = 0;
    set_dly(1, 4, 3);
    @(negedge clk_i); cmd_i[1] = 1'b0;
    fork
      count_gap(1, 1'b0, gap, bad);
      repeat (6) begin
        @(negedge clk_i);
        if (hi_o[0] !== h0 || lo_o[0] !== l0) moved = 1;
      end
    join
    chk(gap == 3, "R9", gap, 3);
    chk(!moved, "R9", int'(moved), 0);
    edge_case(1, 1'b1, 4, "R9");
  endtask

  initial begin
    t_reset;
    t_basic;
    t_zero;
    t_cancel;
    t_dly_change;
    t_indep;
    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule